// File: doc/BRIEF.md
# Low-Power Stop Wakeup Detector

This block raises a single wakeup line that brings a stopped processor out of its low-power state. Software first programs a small control register with an arm bit and a three-bit wakeup threshold. Once the processor reports that it has entered stop mode, the block checks the request and level inputs from two interrupt controllers. It raises the wakeup line when any pending request sits above the threshold.

The decision path from the request inputs to the wakeup output contains no flip-flop, so it still works after every clock in the system has been halted. The only clocked state is the control register, which is written before stop is entered. The hardware limits the threshold to at most 6, so a level-7 request can always end stop mode, even when software programs 7.

Top module: `lp_wake_detect`

## Requirements
- R1: After reset, the control register reads 0x00 and wakeup is low.
- R2: A write with `cfg_wr` high stores the arm bit in bit 7 and the threshold in bits 6:4 on the next clock edge. Bits 3:0 always read as zero.
- R3: While the arm bit (bit 7) is clear, wakeup stays low whatever the requests are.
- R4: While `stop_active` is low, wakeup stays low whatever the requests are.
- R5: While armed and stopped, wakeup is high exactly when some source has its request bit set and its 3-bit level strictly greater than the effective threshold.
- R6: A programmed threshold of 7 acts as 6. A level-7 request therefore always wakes an armed, stopped processor, and a level-6 request does not wake it under that setting.
- R7: Wakeup follows changes on the request, level and stop inputs without waiting for any clock edge.
- R8: Sources of both controllers are combined by OR. A source whose request bit is low has no effect, whatever its level. A level-0 request never wakes the processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Write data: bit 7 arm, bits 6:4 threshold |
| cfg_q | output | 8 | Control register contents, bits 3:0 zero |
| stop_active | input | 1 | Processor has entered stop mode |
| a_req | input | NA | Request bits of controller A |
| a_lvl | input | 3*NA | Levels of controller A, source i at bits 3i+2:3i |
| b_req | input | NB | Request bits of controller B |
| b_lvl | input | 3*NB | Levels of controller B, source i at bits 3i+2:3i |
| wakeup | output | 1 | Wakeup request to exit stop mode |

## Verification
Random stimulus varies the arm bit, the threshold, the stop flag and every request and level of both controllers. A reference function checks each of these patterns, which separates a wrong comparison, a missing clamp or a dropped controller from a correct result. Directed cases set the boundaries:
- a threshold of 7 with level 7 against level 6, which shows whether the clamp is present;
- a threshold equal to the level against one less than the level, which tells a strict comparison from a non-strict one;
- level 0 with threshold 0;
- a high level with its request bit low.

Inputs change between clock edges and wakeup is sampled before the next edge, which shows that no register sits in the decision path.

// File: rtl/lp_wake_detect.sv
module lp_wake_detect #(
  parameter int NA = 8,
  parameter int NB = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_q,
  input  logic            stop_active,
  input  logic [NA-1:0]   a_req,
  input  logic [3*NA-1:0] a_lvl,
  input  logic [NB-1:0]   b_req,
  input  logic [3*NB-1:0] b_lvl,
  output logic            wakeup
);
  logic       arm;
  logic [2:0] thr;
  logic [2:0] eff_thr;
  logic [NA-1:0] a_hit;
  logic [NB-1:0] b_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arm <= 1'b0;
      thr <= 3'd0;
    end else if (cfg_wr) begin
      arm <= cfg_wdata[7];
      thr <= cfg_wdata[6:4];
    end

  assign cfg_q   = {arm, thr, 4'b0000};
  assign eff_thr = (thr == 3'd7) ? 3'd6 : thr;

  for (genvar i = 0; i < NA; i++) begin : g_a
    assign a_hit[i] = a_req[i] && (a_lvl[3*i +: 3] > eff_thr);
  end
  for (genvar i = 0; i < NB; i++) begin : g_b
    assign b_hit[i] = b_req[i] && (b_lvl[3*i +: 3] > eff_thr);
  end

  assign wakeup = stop_active && arm && ((|a_hit) || (|b_hit));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (cfg_q == 8'h00));
  assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_q[7:4] == $past(cfg_wdata[7:4])));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_q));
  assert_arm_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[7] |-> !wakeup);
  assert_stop_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_active |-> !wakeup);
  assert_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req == '0 && b_req == '0) |-> !wakeup);
endmodule

// File: tb/test_lp_wake_detect.sv
module test_lp_wake_detect;
  localparam int NA = 8;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_q;
  logic stop_active = 1'b0;
  logic [NA-1:0] a_req = '0;
  logic [3*NA-1:0] a_lvl = '0;
  logic [NB-1:0] b_req = '0;
  logic [3*NB-1:0] b_lvl = '0;
  logic wakeup;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] m_cfg = 8'h00;

  always #2 clk = ~clk;

  lp_wake_detect #(.NA(NA), .NB(NB)) i_lp_wake_detect (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .stop_active(stop_active), .a_req(a_req), .a_lvl(a_lvl),
    .b_req(b_req), .b_lvl(b_lvl), .wakeup(wakeup));

  function automatic logic exp_wake(logic [7:0] c, logic st,
      logic [NA-1:0] ar, logic [3*NA-1:0] al,
      logic [NB-1:0] br, logic [3*NB-1:0] bl);
    logic [2:0] t;
    logic w;
    t = (c[6:4] == 3'd7) ? 3'd6 : c[6:4];
    w = 1'b0;
    for (int i = 0; i < NA; i++) if (ar[i] && al[3*i +: 3] > t) w = 1'b1;
    for (int i = 0; i < NB; i++) if (br[i] && bl[3*i +: 3] > t) w = 1'b1;
    return w && st && c[7];
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_cfg = {d[7:4], 4'b0000};
    check("R2", cfg_q, m_cfg);
  endtask

  task automatic chk_wake(string req);
    #1;
    check(req, {7'd0, wakeup},
          {7'd0, exp_wake(m_cfg, stop_active, a_req, a_lvl, b_req, b_lvl)});
  endtask

  task automatic one_src(bit ctl_b, int idx, logic [2:0] lvl);
    a_req = '0; b_req = '0; a_lvl = '0; b_lvl = '0;
    if (ctl_b) begin b_req[idx] = 1'b1; b_lvl[3*idx +: 3] = lvl; end
    else begin a_req[idx] = 1'b1; a_lvl[3*idx +: 3] = lvl; end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", cfg_q, 8'h00);
    check("R1", {7'd0, wakeup}, 8'h00);

    write_cfg(8'hAF);
    check("R2", cfg_q, 8'hA0);

    stop_active = 1'b1;
    one_src(1'b0, 3, 3'd7);
    write_cfg(8'h70);
    check("R3", {7'd0, wakeup}, 8'h00);

    write_cfg(8'hF0);
    one_src(1'b0, 3, 3'd7);
    #1 check("R6", {7'd0, wakeup}, 8'h01);
    one_src(1'b1, 5, 3'd6);
    #1 check("R6", {7'd0, wakeup}, 8'h00);

    write_cfg(8'hB0);
    one_src(1'b1, 0, 3'd3);
    #1 check("R5", {7'd0, wakeup}, 8'h00);
    one_src(1'b1, 0, 3'd4);
    #1 check("R5", {7'd0, wakeup}, 8'h01);
    stop_active = 1'b0;
    #1 check("R4", {7'd0, wakeup}, 8'h00);
    stop_active = 1'b1;
    #1 check("R7", {7'd0, wakeup}, 8'h01);

    write_cfg(8'h80);
    one_src(1'b0, 7, 3'd0);
    #1 check("R8", {7'd0, wakeup}, 8'h00);
    a_req = '0; b_req = '0; a_lvl = '1; b_lvl = '1;
    #1 check("R8", {7'd0, wakeup}, 8'h00);
    b_req[NB-1] = 1'b1;
    #1 check("R8", {7'd0, wakeup}, 8'h01);

    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 3) == 0) write_cfg(8'($urandom));
      @(negedge clk);
      stop_active = ($urandom_range(0, 4) != 0);
      a_req = NA'($urandom & $urandom);
      b_req = NB'($urandom & $urandom);
      a_lvl = (3*NA)'($urandom);
      b_lvl = (3*NB)'($urandom);
      chk_wake("R5");
      if (k % 2 == 0) begin
        a_req = NA'($urandom & $urandom & $urandom);
        chk_wake("R7");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule